// File: doc/BRIEF.md
# Per-Operand Signedness Multiplier with Q15 Scaler

This block multiplies two 16-bit operands in a single clock cycle and registers the 32-bit result. Each operand has its own flag that selects two's-complement or plain binary. Before the multiply, each operand is widened by one bit according to its flag, so unsigned-by-unsigned and mixed-sign products come out exact. The result is always delivered as a 32-bit two's-complement word.

For Q15 fractional arithmetic, the product of two signed operands carries a redundant sign bit. When the fractional-mode input is high and both operands are marked signed, a one-bit left scaler removes that bit and fills the low bit with zero. In every other combination the product passes through unscaled. The single overflow case, where -1.0 is multiplied by -1.0, wraps to the most negative 32-bit value and is passed on unchanged for a later saturation stage. A valid strobe travels with the data and has exactly one cycle of latency.

Top module: `smul16_frac`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_vld` is 0 and `res` is 0.
- R2: `res_vld` is high in the cycle after `in_vld` was high, and low in the cycle after `in_vld` was low.
- R3: With both sign flags low (1 = signed, 0 = unsigned), `res` equals the exact unsigned product of the two operands (for example, 0xFFFF × 0xFFFF = 0xFFFE0001).
- R4: With both sign flags high and `frac_en` low, `res` equals the exact two's-complement product.
- R5: With exactly one sign flag high, `res` is the exact product of one signed and one unsigned operand, as a 32-bit two's-complement word (for example, signed 0xFFFF × unsigned 0xFFFF = 0xFFFF0001).
- R6: With `frac_en` high and both sign flags high, `res` is the signed product shifted left by one bit, with bit 0 equal to 0.
- R7: With `frac_en` high and at least one sign flag low, no shift is applied: `res` equals the same product that `frac_en` low would give.
- R8: Fractional signed 0x8000 × 0x8000 gives 0x80000000. This wrapped value is passed through without saturation.
- R9: A cycle with `in_vld` low leaves `res` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| op_x | input | 16 | First operand |
| op_y | input | 16 | Second operand |
| x_signed | input | 1 | 1: treat op_x as two's complement |
| y_signed | input | 1 | 1: treat op_y as two's complement |
| frac_en | input | 1 | Q15 mode: scale the signed-by-signed product left by one bit |
| res_vld | output | 1 | Result valid |
| res | output | 32 | Registered product |

## Verification
Each internal fault has a distinct effect at the ports, one cycle after the faulty operation. A wrong widening flag corrupts only the upper half of `res`, and only when the affected operand has its top bit set. The bench therefore drives negative-looking operands under all four flag combinations. If the scaler enable decodes the wrong condition, bit 0 and the magnitude of `res` become wrong in just one of the eight mode combinations. If the valid pipeline is out of step, `res_vld` is misaligned from the first transfer onward and the scoreboard queue falls out of order.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int unsigned OP_W  = 16;
    localparam int unsigned RES_W = 2 * OP_W;

    // Operand together with its signedness flag
    typedef struct packed {
        logic [OP_W-1:0] val;
        logic            sgn;
    } operand_t;

    // Combined request presented on one cycle
    typedef struct packed {
        operand_t x;
        operand_t y;
        logic     frac;
    } mul_req_t;

    typedef enum logic [1:0] {
        SIGN_UU = 2'b00,
        SIGN_US = 2'b01,
        SIGN_SU = 2'b10,
        SIGN_SS = 2'b11
    } sign_mix_e;

    function automatic sign_mix_e sign_mix(input operand_t x, input operand_t y);
        return sign_mix_e'({x.sgn, y.sgn});
    endfunction

    // Q15 scaling applies only in fractional mode with both operands signed
    function automatic logic scale_needed(input mul_req_t r);
        return r.frac && (sign_mix(r.x, r.y) == SIGN_SS);
    endfunction

endpackage

// File: rtl/smul_opext.sv
module smul_opext #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   val,
    input  logic           sgn,
    output logic signed [W:0] ext
);
    // Top bit is a copy of the operand MSB only when signed
    always_comb begin
        ext = $signed({sgn & val[W-1], val});
    end
endmodule

// File: rtl/smul_core.sv
module smul_core #(
    parameter int unsigned W = 16
) (
    input  logic signed [W:0]   ea,
    input  logic signed [W:0]   eb,
    output logic [2*W-1:0]      prod
);
    localparam int unsigned FW = 2 * (W + 1);

    logic signed [FW-1:0] full;

    always_comb begin
        full = FW'(ea) * FW'(eb);
    end

    // Exact product always fits in 2W bits of two's complement or unsigned
    assign prod = full[2*W-1:0];
endmodule

// File: rtl/smul_scaler.sv
module smul_scaler #(
    parameter int unsigned PW = 32
) (
    input  logic [PW-1:0] din,
    input  logic          shift_en,
    output logic [PW-1:0] dout
);
    always_comb begin
        if (shift_en) dout = {din[PW-2:0], 1'b0};
        else          dout = din;
    end
endmodule

// File: rtl/smul16_frac.sv
module smul16_frac
    import smul_pkg::*;
#(
    parameter int unsigned W = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [W-1:0]   op_x,
    input  logic [W-1:0]   op_y,
    input  logic           x_signed,
    input  logic           y_signed,
    input  logic           frac_en,
    output logic           res_vld,
    output logic [2*W-1:0] res
);
    localparam int unsigned PW   = 2 * W;
    localparam int unsigned N_OP = 2;

    logic [W-1:0]        op_val [N_OP];
    logic                op_sgn [N_OP];
    logic signed [W:0]   op_ext [N_OP];
    logic [PW-1:0]       raw_prod;
    logic [PW-1:0]       scaled;
    logic                do_shift;

    assign op_val[0] = op_x;
    assign op_val[1] = op_y;
    assign op_sgn[0] = x_signed;
    assign op_sgn[1] = y_signed;

    for (genvar i = 0; i < N_OP; i++) begin : g_ext
        smul_opext #(.W(W)) u_ext (
            .val (op_val[i]),
            .sgn (op_sgn[i]),
            .ext (op_ext[i])
        );
    end

    smul_core #(.W(W)) u_core (
        .ea   (op_ext[0]),
        .eb   (op_ext[1]),
        .prod (raw_prod)
    );

    assign do_shift = frac_en & x_signed & y_signed;

    smul_scaler #(.PW(PW)) u_scale (
        .din      (raw_prod),
        .shift_en (do_shift),
        .dout     (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res     <= '0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) res <= scaled;
        end
    end
endmodule

// File: rtl/smul16_frac_chk.sv
module smul16_frac_chk #(
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_vld,
    input logic [W-1:0]   op_x,
    input logic [W-1:0]   op_y,
    input logic           x_signed,
    input logic           y_signed,
    input logic           frac_en,
    input logic           res_vld,
    input logic [2*W-1:0] res
);
    localparam logic [W-1:0]   MINV  = {1'b1, {(W-1){1'b0}}};
    localparam logic [2*W-1:0] WRAPV = {1'b1, {(2*W-1){1'b0}}};

    assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> res_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !res_vld);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(res));

    assert_frac_lsb_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && frac_en && x_signed && y_signed) |=> (res[0] == 1'b0));

    assert_frac_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && frac_en && x_signed && y_signed && op_x == MINV && op_y == MINV)
        |=> (res == WRAPV));

    assert_unsigned_lsb_R3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !x_signed && !y_signed) |=> (res[0] == ($past(op_x[0]) & $past(op_y[0]))));
endmodule

bind smul16_frac smul16_frac_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_x(op_x), .op_y(op_y),
    .x_signed(x_signed), .y_signed(y_signed), .frac_en(frac_en),
    .res_vld(res_vld), .res(res)
);

// File: tb/smul16_frac_test.sv
module smul16_frac_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [15:0] op_x, op_y;
    logic        x_signed, y_signed, frac_en;
    logic        res_vld;
    logic [31:0] res;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [31:0] last_exp = '0;

    always #2.5 clk = ~clk;

    smul16_frac uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_x(op_x), .op_y(op_y),
        .x_signed(x_signed), .y_signed(y_signed), .frac_en(frac_en),
        .res_vld(res_vld), .res(res)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic sa, input logic sb_, input logic fr);
        longint ea, eb, p;
        ea = sa  ? longint'($signed(a)) : longint'({48'd0, a});
        eb = sb_ ? longint'($signed(b)) : longint'({48'd0, b});
        p  = ea * eb;
        if (fr && sa && sb_) p = p * 2;
        return p[31:0];
    endfunction

    function automatic string tag_of(input logic sa, input logic sb_, input logic fr);
        if (sa && sb_) return fr ? "R6" : "R4";
        if (!sa && !sb_) return fr ? "R7" : "R3";
        return fr ? "R7" : "R5";
    endfunction

    // Driver: one operation per negedge, pushes the expected result
    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic sa, input logic sb_, input logic fr, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1; op_x = a; op_y = b; x_signed = sa; y_signed = sb_; frac_en = fr;
        e.val = model(a, b, sa, sb_, fr);
        e.tag = (tag == "") ? tag_of(sa, sb_, fr) : tag;
        sb.push_back(e);
        last_exp = e.val;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            op_x = 16'hA5A5; op_y = 16'h5A5A;
            x_signed = 1'b1; y_signed = 1'b1; frac_en = 1'b1;
        end
    endtask

    // Monitor: checks results away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (res_vld) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, res, e.val);
                end
            end else if (sb.size() != 0 && !in_vld) begin
                check("R2 missing valid", 32'd0, 32'd1);
            end
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0; op_x = '0; op_y = '0;
        x_signed = 1'b0; y_signed = 1'b0; frac_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 vld in reset", {31'd0, res_vld}, 32'd0);
        check("R1 res in reset", res, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after reset", {31'd0, res_vld}, 32'd0);
        check("R1 res after reset", res, 32'd0);

        drive(16'hFFFF, 16'hFFFF, 0, 0, 0, "R3 max unsigned");
        drive(16'h8000, 16'h0002, 0, 0, 0, "R3");
        drive(16'hFFFF, 16'hFFFF, 1, 1, 0, "R4 -1*-1");
        drive(16'h8000, 16'h7FFF, 1, 1, 0, "R4");
        drive(16'hFFFF, 16'hFFFF, 1, 0, 0, "R5 s*u");
        drive(16'h0003, 16'h8001, 0, 1, 0, "R5 u*s");
        drive(16'h4000, 16'h4000, 1, 1, 1, "R6 0.5*0.5");
        drive(16'hC000, 16'h2000, 1, 1, 1, "R6 neg");
        drive(16'h4000, 16'h4000, 1, 0, 1, "R7 mixed no shift");
        drive(16'hFFFF, 16'h8000, 0, 0, 1, "R7 unsigned no shift");
        drive(16'h8000, 16'h8000, 1, 1, 1, "R8 wrap");
        drive(16'h8000, 16'h8000, 1, 1, 0, "R4 min*min");
        idle(1);

        // R9: idle cycles with changing inputs must not disturb res
        idle(3);
        check("R9 hold", res, last_exp);
        check("R2 idle vld", {31'd0, res_vld}, 32'd0);

        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = $urandom();
            drive(r[15:0], r[31:16], r[0] ^ r[17], r[5] ^ r[20], r[9], "");
            if (r[3] && r[7]) idle(1);
        end
        idle(2);
        check("R9 hold end", res, last_exp);
        check("R2 queue drained", sb.size(), 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule